// File: doc/BRIEF.md
# Split-Access Port Event Counter Bank

This block keeps the management-side event counts for a twelve-port repeater. Every port owns four counters: short events, late events, collisions and auto-partition occurrences. Per-port detectors outside the block send one-cycle increment pulses. The counters are reached through a synchronous 16-bit register port. That port has a page-select bit, a slot address and separate read and write strobes.

The short, late and collision counters are 32 bits wide. Each of them is moved as a pair of 16-bit transfers through one shared holding register. On a read, the first transfer captures the whole count and returns the upper word. The second transfer returns the lower word of that same captured value. Writes also travel upper word first. The value is committed as one 32-bit update when the lower word arrives. Any access to some other register in the middle breaks the pair. The 16-bit partition counter moves in a single transfer.

Writes are accepted only while the management-enable input is low. A write that arrives while it is high is dropped and flagged.

Top module: `evcnt_bank`

## Requirements
- R1: The register address is `slot*4 + kind`, with slot in 0..5 and kind 0 = short event, 1 = late event, 2 = collision, 3 = auto-partition. Page 0 selects ports 0..5 (port = slot) and page 1 selects ports 6..11 (port = slot + 6). A read of address 24..31 returns 0.
- R2: After reset every counter is zero, `rdata` is 0 and `wr_reject` is 0.
- R3: An increment pulse adds one to its counter in that cycle. A counter at its maximum value (all ones: 32 bits for kinds 0..2, 16 bits for kind 3) wraps to zero.
- R4: A read of a 32-bit counter with no read pair open on that address captures the full count into the holding register and opens a read pair. `rdata` shows the upper 16 bits one cycle after the strobe.
- R5: The next access, if it is a read of the same page and address, returns the lower 16 bits of the captured value one cycle later and closes the pair. This holds even when the counter changed after the capture.
- R6: Any access in between abandons an open pair: a read or write of a different address, a write to the same address, or a rejected write. The next access to the counter is then treated as a first access.
- R7: A 32-bit write is two consecutive writes to the same address. The first carries the upper word and is held. The second carries the lower word and loads all 32 bits in one cycle. An intervening access abandons the held word.
- R8: In the cycle a write loads a counter, an increment pulse for that counter is discarded.
- R9: The auto-partition counter (kind 3) is read and written as a single 16-bit transfer.
- R10: Reads never change a counter, and `rdata` keeps its value in cycles without a read.
- R11: A write while `mgmt_en` is 1 changes no counter, and `wr_reject` is 1 in the following cycle. After any other cycle `wr_reject` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page | input | 1 | Register page select |
| addr | input | 5 | Register address within the page |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (takes precedence over rd) |
| wdata | input | 16 | Write data |
| mgmt_en | input | 1 | Management enable; writes are refused while high |
| inc_short | input | 12 | Short-event increment pulses, one per port |
| inc_late | input | 12 | Late-event increment pulses, one per port |
| inc_col | input | 12 | Collision increment pulses, one per port |
| inc_part | input | 12 | Auto-partition increment pulses, one per port |
| rdata | output | 16 | Registered read data |
| wr_reject | output | 1 | One-cycle flag for a refused write |

## Verification
The bench pulses a counter between the two halves of a read. A design that read the live count on the second access would return a torn value there. It breaks read and write pairs with foreign reads, with writes and with refused writes. A design that kept the pairing open would then return a lower word, or load a stale upper word, where a fresh first access was expected. It drives increments into the exact cycle a write commits, and it loads all-ones values to force wraps. Increment-wins priority or saturation would both show up in the readback. Random mixed traffic, with live increments on every port, is compared against a bench model across both pages.

// File: rtl/evcnt_bank.sv
module evcnt_bank #(
  parameter int NPORT    = 12,
  parameter int PER_PAGE = 6,
  parameter int DW       = 16,
  parameter int CW       = 2 * DW,
  parameter int AW       = $clog2(PER_PAGE * 4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             mgmt_en,
  input  logic [NPORT-1:0] inc_short,
  input  logic [NPORT-1:0] inc_late,
  input  logic [NPORT-1:0] inc_col,
  input  logic [NPORT-1:0] inc_part,
  output logic [DW-1:0]    rdata,
  output logic             wr_reject
);
  localparam int PIW = $clog2(NPORT);
  localparam int NREG = PER_PAGE * 4;

  logic [CW-1:0] c32 [3][NPORT];
  logic [DW-1:0] cpart [NPORT];
  logic [CW-1:0] hold;
  logic          pend, pend_wr;
  logic [AW:0]   pend_key;

  logic [2:0][NPORT-1:0] incs;
  assign incs = {inc_col, inc_late, inc_short};

  wire [AW:0]    key   = {page, addr};
  wire           valid = addr < AW'(NREG);
  wire [1:0]     kind  = addr[1:0];
  wire [PIW-1:0] port  = PIW'(addr[AW-1:2]) + (page ? PIW'(PER_PAGE) : '0);
  wire [PIW-1:0] psafe = valid ? port : '0;
  wire           is32  = valid && kind != 2'd3;
  wire           is16  = valid && kind == 2'd3;
  wire [1:0]     k32   = is32 ? kind : 2'd0;
  wire           wr_ok = wr && !mgmt_en;
  wire           cont  = pend && pend_key == key && pend_wr == wr;
  wire           commit32 = wr_ok && is32 && cont;
  wire           commit16 = wr_ok && is16;
  wire [CW-1:0]  cur32 = c32[k32][psafe];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < NPORT; p++) c32[k][p] <= '0;
      for (int p = 0; p < NPORT; p++) cpart[p] <= '0;
    end else begin
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < NPORT; p++)
          if (commit32 && k32 == 2'(k) && psafe == PIW'(p))
            c32[k][p] <= {hold[CW-1:DW], wdata};
          else
            c32[k][p] <= c32[k][p] + CW'(incs[k][p]);
      for (int p = 0; p < NPORT; p++)
        if (commit16 && psafe == PIW'(p)) cpart[p] <= wdata;
        else cpart[p] <= cpart[p] + DW'(inc_part[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      pend      <= 1'b0;
      pend_wr   <= 1'b0;
      pend_key  <= '0;
      rdata     <= '0;
      wr_reject <= 1'b0;
    end else begin
      wr_reject <= wr && mgmt_en;
      if (wr) begin
        if (wr_ok && is32 && !cont) begin
          hold[CW-1:DW] <= wdata;
          pend     <= 1'b1;
          pend_wr  <= 1'b1;
          pend_key <= key;
        end else begin
          pend <= 1'b0;
        end
      end else if (rd) begin
        if (is32 && cont) begin
          rdata <= hold[DW-1:0];
          pend  <= 1'b0;
        end else if (is32) begin
          hold     <= cur32;
          rdata    <= cur32[CW-1:DW];
          pend     <= 1'b1;
          pend_wr  <= 1'b0;
          pend_key <= key;
        end else begin
          rdata <= is16 ? cpart[psafe] : '0;
          pend  <= 1'b0;
        end
      end
    end
  end
endmodule

module evcnt_bank_chk #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd,
  input logic          wr,
  input logic          mgmt_en,
  input logic          wr_reject,
  input logic [DW-1:0] rdata,
  input logic          pend,
  input logic          pend_wr,
  input logic [AW:0]   pend_key,
  input logic [AW:0]   key,
  input logic          is32
);
  // R11
  rej_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && mgmt_en |=> wr_reject);
  // R11
  no_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && mgmt_en) |=> !wr_reject);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && !wr) |=> $stable(rdata));
  // R4
  pair_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !wr && is32 && !pend |=> pend && !pend_wr);
  // R6
  pair_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) && pend && key != pend_key |=> !pend || pend_key != $past(pend_key));
  // R6
  rej_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && mgmt_en |=> !pend);
endmodule

bind evcnt_bank evcnt_bank_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_evcnt_bank.sv
module sim_evcnt_bank;
  localparam int CLK_P = 10;
  localparam int NP = 12;
  localparam int PP = 6;

  logic clk = 0, rst_n = 0;
  logic page = 0, rd = 0, wr = 0, mgmt_en = 0;
  logic [4:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [NP-1:0] i_s = 0, i_l = 0, i_c = 0, i_p = 0;
  logic [15:0] rdata;
  logic wr_reject;

  int checks = 0, failures = 0;
  bit rand_on = 0;

  logic [31:0] m32 [3][NP];
  logic [15:0] mp [NP];
  bit mc_on = 0;
  int mc_k = 0, mc_p = 0;
  logic [31:0] mc_val = 0;

  always #(CLK_P/2) clk = ~clk;

  evcnt_bank u0 (
    .clk(clk), .rst_n(rst_n), .page(page), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .mgmt_en(mgmt_en), .inc_short(i_s), .inc_late(i_l),
    .inc_col(i_c), .inc_part(i_p), .rdata(rdata), .wr_reject(wr_reject)
  );

  function automatic bit incb(int k, int p);
    case (k)
      0: return i_s[p];
      1: return i_l[p];
      2: return i_c[p];
      default: return i_p[p];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) for (int p = 0; p < NP; p++) m32[k][p] = 0;
      for (int p = 0; p < NP; p++) mp[p] = 0;
    end else begin
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < NP; p++)
          if (mc_on && mc_k == k && mc_p == p) m32[k][p] = mc_val;
          else m32[k][p] = m32[k][p] + 32'(incb(k, p));
      for (int p = 0; p < NP; p++)
        if (mc_on && mc_k == 3 && mc_p == p) mp[p] = mc_val[15:0];
        else mp[p] = mp[p] + 16'(incb(3, p));
    end
  end

  always @(negedge clk)
    if (rand_on) begin
      i_s = NP'($urandom & $urandom & $urandom);
      i_l = NP'($urandom & $urandom & $urandom);
      i_c = NP'($urandom & $urandom & $urandom);
      i_p = NP'($urandom & $urandom & $urandom);
    end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic incs_off();
    rand_on = 0;
    i_s = 0; i_l = 0; i_c = 0; i_p = 0;
  endtask

  task automatic acc(bit r, bit w, bit pg, int a, logic [15:0] d,
                     bit cm, int ck, int cp, logic [31:0] cv, output logic [15:0] got);
    rd = r; wr = w; page = pg; addr = 5'(a); wdata = d;
    mc_on = cm; mc_k = ck; mc_p = cp; mc_val = cv;
    @(negedge clk);
    rd = 0; wr = 0; mc_on = 0;
    got = rdata;
  endtask

  task automatic rd32(bit pg, int slot, int k, output logic [31:0] got, output logic [31:0] exp);
    logic [15:0] hi, lo;
    exp = m32[k][pg*PP + slot];
    acc(1, 0, pg, slot*4 + k, 0, 0, 0, 0, 0, hi);
    acc(1, 0, pg, slot*4 + k, 0, 0, 0, 0, 0, lo);
    got = {hi, lo};
  endtask

  task automatic rd16(bit pg, int slot, output logic [15:0] got, output logic [15:0] exp);
    exp = mp[pg*PP + slot];
    acc(1, 0, pg, slot*4 + 3, 0, 0, 0, 0, 0, got);
  endtask

  task automatic wr32(bit pg, int slot, int k, logic [31:0] v);
    logic [15:0] g;
    acc(0, 1, pg, slot*4 + k, v[31:16], 0, 0, 0, 0, g);
    acc(0, 1, pg, slot*4 + k, v[15:0], !mgmt_en, k, pg*PP + slot, v, g);
  endtask

  task automatic wr16(bit pg, int slot, logic [15:0] v);
    logic [15:0] g;
    acc(0, 1, pg, slot*4 + 3, v, !mgmt_en, 3, pg*PP + slot, 32'(v), g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] g32, e32, g32b;
    logic [15:0] g16, e16;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    chk("R2 rdata", 32'(rdata), 0);
    chk("R2 wr_reject", 32'(wr_reject), 0);
    rd32(1, 5, 2, g32, e32); chk("R2 counter zero", g32, 0);
    rd16(0, 0, g16, e16);    chk("R2 partition zero", 32'(g16), 0);

    // R1 page mapping
    wr32(1, 0, 0, 32'hCAFE_BABE);
    rd32(0, 0, 0, g32, e32); chk("R1 page0 port0 untouched", g32, 0);
    rd32(1, 0, 0, g32, e32); chk("R1 page1 port6", g32, 32'hCAFE_BABE);
    acc(1, 0, 0, 26, 0, 0, 0, 0, 0, g16); chk("R1 unmapped addr", 32'(g16), 0);

    // R3 wrap
    wr32(1, 3, 2, 32'hFFFF_FFFF);
    i_c[9] = 1; acc(0, 0, 0, 0, 0, 0, 0, 0, 0, g16); i_c[9] = 0;
    rd32(1, 3, 2, g32, e32); chk("R3 wrap 32", g32, 0);
    wr16(0, 4, 16'hFFFF);
    i_p[4] = 1; acc(0, 0, 0, 0, 0, 0, 0, 0, 0, g16); i_p[4] = 0;
    rd16(0, 4, g16, e16); chk("R3 R9 wrap 16", 32'(g16), 0);

    // R4 R5 snapshot across increment
    wr32(0, 2, 0, 32'h0000_FFFF);
    i_s[2] = 1; acc(1, 0, 0, 8, 0, 0, 0, 0, 0, g16); i_s[2] = 0;
    chk("R4 upper word", 32'(g16), 0);
    acc(1, 0, 0, 8, 0, 0, 0, 0, 0, g16); chk("R5 lower from snapshot", 32'(g16), 32'hFFFF);
    rd32(0, 2, 0, g32, e32); chk("R5 fresh read", g32, 32'h0001_0000);

    // R10 reads leave values
    rd32(0, 2, 0, g32b, e32); chk("R10 repeat read", g32b, g32);
    acc(0, 0, 0, 0, 0, 0, 0, 0, 0, g16); chk("R10 rdata holds", 32'(g16), 0);

    // R6 read pair abort
    wr32(0, 1, 1, 32'h1234_5678);
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16); chk("R6 first", 32'(g16), 32'h1234);
    acc(1, 0, 0, 3, 0, 0, 0, 0, 0, g16);
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16); chk("R6 foreign read aborts", 32'(g16), 32'h1234);
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16); chk("R6 pair completes", 32'(g16), 32'h5678);
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16);
    mgmt_en = 1; acc(0, 1, 0, 3, 16'h7, 0, 0, 0, 0, g16); mgmt_en = 0;
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16); chk("R6 refused write aborts", 32'(g16), 32'h1234);
    acc(1, 0, 0, 5, 0, 0, 0, 0, 0, g16);

    // R7 write pair abort
    acc(0, 1, 0, 9, 16'hAAAA, 0, 0, 0, 0, g16);
    acc(1, 0, 0, 3, 0, 0, 0, 0, 0, g16);
    acc(0, 1, 0, 9, 16'h1111, 0, 0, 0, 0, g16);
    acc(0, 1, 0, 9, 16'h2222, 1, 1, 2, 32'h1111_2222, g16);
    rd32(0, 2, 1, g32, e32); chk("R7 write pair restart", g32, 32'h1111_2222);

    // R8 commit drops increment
    i_l[7] = 1; wr32(1, 1, 1, 32'h0BAD_F00D); i_l[7] = 0;
    rd32(1, 1, 1, g32, e32); chk("R8 increment dropped", g32, 32'h0BAD_F00D);

    // R11 refused writes
    mgmt_en = 1;
    acc(0, 1, 0, 19, 16'h0055, 0, 0, 0, 0, g16);
    chk("R11 flag set", 32'(wr_reject), 1);
    wr32(1, 5, 0, 32'h9999_9999);
    mgmt_en = 0;
    rd16(0, 4, g16, e16); chk("R11 partition unchanged", 32'(g16), 0);
    rd32(1, 5, 0, g32, e32); chk("R11 32-bit unchanged", g32, 0);
    chk("R11 flag clear", 32'(wr_reject), 0);

    // random mixed traffic
    rand_on = 1;
    for (int i = 0; i < 400; i++) begin
      automatic bit pg = 1'($urandom);
      automatic int sl = $urandom % PP;
      automatic int k = $urandom % 4;
      automatic logic [31:0] v = ($urandom % 4 == 0) ? (32'hFFFF_FFF0 | ($urandom & 15)) : $urandom;
      case ($urandom % 3)
        0: if (k == 3) wr16(pg, sl, v[15:0]); else wr32(pg, sl, k, v);
        default: if (k == 3) begin
          rd16(pg, sl, g16, e16); chk("R3 R9 random 16", 32'(g16), 32'(e16));
        end else begin
          rd32(pg, sl, k, g32, e32); chk("R3 R5 random 32", g32, e32);
        end
      endcase
    end
    incs_off();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      rd32(1'(p / PP), p % PP, 1, g32, e32); chk("R1 sweep late", g32, e32);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule